// File: doc/BRIEF.md
# SATA Bridge Control Register Bank

This block is the processor-facing register bank of a SATA device-side DMA bridge. A CPU reaches it over an AXI4-Lite slave port. Through it the CPU sets three DDR base addresses: one for outgoing frames, one for incoming frames that carry no data, and one for incoming data frames. It also writes a control word that can launch a transmit or reset the bridge, and it acknowledges interrupts through a clear register. The bridge datapaths drive the block's status inputs. They report an error code, count received words, flag that a non-data frame has arrived, and signal completion in each direction.

Reads and writes share offsets but reach different registers. Offset 0x04 is the non-data receive base when written and the error code when read. Offset 0x0C is the data-frame receive base when written and the receive status word when read. Start and reset requests leave the block as single-cycle pulses. The two interrupt lines, and the received-frame-type flag, stay set until software clears them.

Top module: `sata_bridge_regs`

## Requirements
- R1: Writes to offsets 0x00, 0x04 and 0x0C load the transmit base, the non-data receive base and the data receive base respectively. Bits 8:0 of each base always read out as zero on the output ports.
- R2: A write to offset 0x08 loads the frame type from bit 29 (1 = data) and the transmit word count from bits 15:0, onto ports ctl_fis_data and ctl_tx_words. A byte lane whose wstrb bit is 0 leaves its part of the control word unchanged.
- R3: A write to 0x08 with wstrb[3] set issues a one-cycle pulse on ctl_start when bit 30 is 1, and a one-cycle pulse on ctl_reset when bit 31 is 1. A read of 0x08 returns zero.
- R4: A read of 0x04 returns the err_code input as sampled on the cycle the read address is accepted.
- R5: A read of 0x0C returns the receive flag in bit 31, zeros in bits 30:24 and the received word count in bits 23:0. The count rises by one on each cycle that rx_word_stb is high.
- R6: Any accepted write to 0x08 clears the received word count, whatever the strobes are. If an increment arrives in the same cycle, the clear wins.
- R7: A pulse on rx_nondata_stb sets the receive flag (1 = non-data frame). The flag holds until a write to 0x10 with bit 29 set, and if a set and a clear arrive in the same cycle, the set wins.
- R8: d2p_done sets irq_d2p and p2d_done sets irq_p2d. Each line holds until a write to 0x10 with bit 31 (for d2p) or bit 30 (for p2d), and a set in the same cycle as a clear wins.
- R9: Writes to unmapped offsets change no output and no readable value. Reads of unmapped offsets return zero. Every response is OKAY (2'b00).
- R10: A write is accepted when awvalid and wvalid are both high and no response is pending. Its bvalid comes one cycle after acceptance. Read data comes with rvalid one cycle after arready. Each response holds until its ready is seen.
- R11: After reset all bases, the control fields, the count, the flag, both interrupts and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| tx_base | output | 32 | Transmit DDR base |
| rx_other_base | output | 32 | Non-data receive DDR base |
| rx_data_base | output | 32 | Data receive DDR base |
| ctl_fis_data | output | 1 | Transmit frame type, 1 = data |
| ctl_tx_words | output | 16 | Transmit word count |
| ctl_start | output | 1 | One-cycle transmit start pulse |
| ctl_reset | output | 1 | One-cycle bridge reset pulse |
| err_code | input | 32 | Error code from the link |
| rx_word_stb | input | 1 | One received word |
| rx_nondata_stb | input | 1 | Non-data frame received |
| d2p_done | input | 1 | Device-to-processor event |
| p2d_done | input | 1 | Processor-to-device event |
| irq_d2p | output | 1 | Device-to-processor interrupt |
| irq_p2d | output | 1 | Processor-to-device interrupt |

## Verification
A write takes effect at the clock edge that accepts it. The base, control and interrupt outputs, and either pulse, are therefore valid in the half cycle after that edge, and the pulse is gone one cycle later. The bench samples at the falling edge that follows acceptance, then again one falling edge on. Read data is captured at the accepting edge and shown one cycle later with rvalid. The bench pushes the expected word into a queue when it issues the read, and a monitor pops it at the falling edge where rvalid is high. Same-cycle races are set up by holding a status strobe high through the accepting edge and dropping it at the next falling edge.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int DW       = 32;
  localparam int STRB_W   = DW / 8;
  localparam int ALIGN_LO = 9;
  localparam int CNT_W    = 24;

  // word indices (byte offset / 4)
  localparam int IDX_TXB  = 0;
  localparam int IDX_RXO  = 1;
  localparam int IDX_CTL  = 2;
  localparam int IDX_RXD  = 3;
  localparam int IDX_ICLR = 4;

  // control and clear bit positions
  localparam int B_RST    = 31;
  localparam int B_START  = 30;
  localparam int B_TYPE   = 29;
  localparam int B_CLR_D2P  = 31;
  localparam int B_CLR_P2D  = 30;
  localparam int B_CLR_FLAG = 29;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [STRB_W-1:0] strb);
    logic [DW-1:0] r;
    for (int b = 0; b < STRB_W; b++)
      r[b*8 +: 8] = strb[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] align_base(input logic [DW-1:0] v);
    return {v[DW-1:ALIGN_LO], {ALIGN_LO{1'b0}}};
  endfunction

  function automatic logic [DW-1:0] status_word(input logic flag,
                                                 input logic [CNT_W-1:0] cnt);
    return {flag, {(DW-1-CNT_W){1'b0}}, cnt};
  endfunction
endpackage

// File: rtl/sbr_axil_if.sv
module sbr_axil_if #(
  parameter int ADDR_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         awaddr,
  input  logic                      awvalid,
  output logic                      awready,
  input  logic [sbr_pkg::DW-1:0]    wdata,
  input  logic [sbr_pkg::STRB_W-1:0] wstrb,
  input  logic                      wvalid,
  output logic                      wready,
  output logic [1:0]                bresp,
  output logic                      bvalid,
  input  logic                      bready,
  input  logic [ADDR_W-1:0]         araddr,
  input  logic                      arvalid,
  output logic                      arready,
  output logic [sbr_pkg::DW-1:0]    rdata,
  output logic [1:0]                rresp,
  output logic                      rvalid,
  input  logic                      rready,
  output logic                      wr_fire,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [sbr_pkg::DW-1:0]    wr_data,
  output logic [sbr_pkg::STRB_W-1:0] wr_strb,
  output logic                      rd_fire,
  output logic [ADDR_W-1:0]         rd_addr,
  input  logic [sbr_pkg::DW-1:0]    rd_word
);
  import sbr_pkg::*;

  assign awready = awvalid && wvalid && !bvalid;
  assign wready  = awready;
  assign wr_fire = awready;
  assign wr_addr = awaddr;
  assign wr_data = wdata;
  assign wr_strb = wstrb;

  assign arready = !rvalid;
  assign rd_fire = arvalid && arready;
  assign rd_addr = araddr;

  assign bresp = RESP_OKAY;
  assign rresp = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr_fire)                bvalid <= 1'b1;
      else if (bvalid && bready)  bvalid <= 1'b0;
      if (rd_fire) begin
        rvalid <= 1'b1;
        rdata  <= rd_word;
      end else if (rvalid && rready) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sbr_ctrl_regs.sv
module sbr_ctrl_regs #(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_fire,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [sbr_pkg::DW-1:0]     wr_data,
  input  logic [sbr_pkg::STRB_W-1:0] wr_strb,
  output logic [sbr_pkg::DW-1:0]     tx_base,
  output logic [sbr_pkg::DW-1:0]     rx_other_base,
  output logic [sbr_pkg::DW-1:0]     rx_data_base,
  output logic                       ctl_fis_data,
  output logic [15:0]                ctl_tx_words,
  output logic                       ctl_start,
  output logic                       ctl_reset,
  output logic                       ctl_wr,
  output logic                       clr_d2p,
  output logic                       clr_p2d,
  output logic                       clr_flag
);
  import sbr_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [DW-1:0] ctl_word;
  logic          sel_txb, sel_rxo, sel_ctl, sel_rxd, sel_iclr;
  logic [DW-1:0] ctl_next;

  assign sel_txb  = wr_fire && (wr_addr[1:0] == 2'b00) && (wr_addr[ADDR_W-1:2] == IDX_W'(IDX_TXB));
  assign sel_rxo  = wr_fire && (wr_addr[1:0] == 2'b00) && (wr_addr[ADDR_W-1:2] == IDX_W'(IDX_RXO));
  assign sel_ctl  = wr_fire && (wr_addr[1:0] == 2'b00) && (wr_addr[ADDR_W-1:2] == IDX_W'(IDX_CTL));
  assign sel_rxd  = wr_fire && (wr_addr[1:0] == 2'b00) && (wr_addr[ADDR_W-1:2] == IDX_W'(IDX_RXD));
  assign sel_iclr = wr_fire && (wr_addr[1:0] == 2'b00) && (wr_addr[ADDR_W-1:2] == IDX_W'(IDX_ICLR));

  assign ctl_wr   = sel_ctl;
  assign ctl_next = merge_bytes(ctl_word, wr_data, wr_strb);

  assign clr_d2p  = sel_iclr && wr_strb[3] && wr_data[B_CLR_D2P];
  assign clr_p2d  = sel_iclr && wr_strb[3] && wr_data[B_CLR_P2D];
  assign clr_flag = sel_iclr && wr_strb[3] && wr_data[B_CLR_FLAG];

  assign ctl_fis_data = ctl_word[B_TYPE];
  assign ctl_tx_words = ctl_word[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_base       <= '0;
      rx_other_base <= '0;
      rx_data_base  <= '0;
      ctl_word      <= '0;
      ctl_start     <= 1'b0;
      ctl_reset     <= 1'b0;
    end else begin
      if (sel_txb) tx_base       <= align_base(merge_bytes(tx_base, wr_data, wr_strb));
      if (sel_rxo) rx_other_base <= align_base(merge_bytes(rx_other_base, wr_data, wr_strb));
      if (sel_rxd) rx_data_base  <= align_base(merge_bytes(rx_data_base, wr_data, wr_strb));
      if (sel_ctl) ctl_word      <= {1'b0, 1'b0, ctl_next[DW-3:0]};
      ctl_start <= sel_ctl && wr_strb[3] && wr_data[B_START];
      ctl_reset <= sel_ctl && wr_strb[3] && wr_data[B_RST];
    end
  end
endmodule

// File: rtl/sbr_status.sv
module sbr_status (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_word_stb,
  input  logic                      rx_nondata_stb,
  input  logic                      d2p_done,
  input  logic                      p2d_done,
  input  logic                      ctl_wr,
  input  logic                      clr_d2p,
  input  logic                      clr_p2d,
  input  logic                      clr_flag,
  output logic [sbr_pkg::CNT_W-1:0] rx_count,
  output logic                      rx_flag,
  output logic                      irq_d2p,
  output logic                      irq_p2d
);
  import sbr_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_count <= '0;
      rx_flag  <= 1'b0;
      irq_d2p  <= 1'b0;
      irq_p2d  <= 1'b0;
    end else begin
      if (ctl_wr)           rx_count <= '0;
      else if (rx_word_stb) rx_count <= rx_count + 1'b1;
      rx_flag <= rx_nondata_stb || (rx_flag && !clr_flag);
      irq_d2p <= d2p_done       || (irq_d2p && !clr_d2p);
      irq_p2d <= p2d_done       || (irq_p2d && !clr_p2d);
    end
  end
endmodule

// File: rtl/sata_bridge_regs.sv
module sata_bridge_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [31:0]       tx_base,
  output logic [31:0]       rx_other_base,
  output logic [31:0]       rx_data_base,
  output logic              ctl_fis_data,
  output logic [15:0]       ctl_tx_words,
  output logic              ctl_start,
  output logic              ctl_reset,
  input  logic [31:0]       err_code,
  input  logic              rx_word_stb,
  input  logic              rx_nondata_stb,
  input  logic              d2p_done,
  input  logic              p2d_done,
  output logic              irq_d2p,
  output logic              irq_p2d
);
  import sbr_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DW-1:0]     wr_data, rd_word;
  logic [STRB_W-1:0] wr_strb;
  logic              ctl_wr, clr_d2p, clr_p2d, clr_flag;
  logic [CNT_W-1:0]  rx_count;
  logic              rx_flag;

  sbr_axil_if #(.ADDR_W(ADDR_W)) u_if (
    .clk, .rst_n, .awaddr, .awvalid, .awready, .wdata, .wstrb, .wvalid, .wready,
    .bresp, .bvalid, .bready, .araddr, .arvalid, .arready, .rdata, .rresp,
    .rvalid, .rready, .wr_fire, .wr_addr, .wr_data, .wr_strb, .rd_fire,
    .rd_addr, .rd_word
  );

  sbr_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rst_n, .wr_fire, .wr_addr, .wr_data, .wr_strb, .tx_base,
    .rx_other_base, .rx_data_base, .ctl_fis_data, .ctl_tx_words, .ctl_start,
    .ctl_reset, .ctl_wr, .clr_d2p, .clr_p2d, .clr_flag
  );

  sbr_status u_stat (
    .clk, .rst_n, .rx_word_stb, .rx_nondata_stb, .d2p_done, .p2d_done,
    .ctl_wr, .clr_d2p, .clr_p2d, .clr_flag, .rx_count, .rx_flag,
    .irq_d2p, .irq_p2d
  );

  always_comb begin
    rd_word = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_addr[ADDR_W-1:2] == IDX_W'(IDX_RXO)) rd_word = err_code;
      if (rd_addr[ADDR_W-1:2] == IDX_W'(IDX_RXD)) rd_word = status_word(rx_flag, rx_count);
    end
  end
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_start,
  input logic        ctl_reset,
  input logic        ctl_wr,
  input logic [23:0] rx_count,
  input logic        rx_flag,
  input logic        rx_nondata_stb,
  input logic        clr_flag,
  input logic        d2p_done,
  input logic        p2d_done,
  input logic        clr_d2p,
  input logic        clr_p2d,
  input logic        irq_d2p,
  input logic        irq_p2d,
  input logic [31:0] tx_base,
  input logic [31:0] rx_other_base,
  input logic [31:0] rx_data_base,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [1:0]  rresp,
  input logic [31:0] rdata
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ctl_start |=> !ctl_start); // R3
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ctl_reset |=> !ctl_reset); // R3
  AST_CTL_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |=> rx_count == 24'd0); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) rx_nondata_stb |=> rx_flag); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rx_flag && !clr_flag |=> rx_flag); // R7
  AST_D2P_SET: assert property (@(posedge clk) disable iff (!rst_n) d2p_done |=> irq_d2p); // R8
  AST_D2P_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq_d2p && !clr_d2p |=> irq_d2p); // R8
  AST_P2D_SET: assert property (@(posedge clk) disable iff (!rst_n) p2d_done |=> irq_p2d); // R8
  AST_P2D_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq_p2d && !clr_p2d |=> irq_p2d); // R8
  AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n) bvalid |-> bresp == 2'b00); // R9
  AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> rresp == 2'b00); // R9
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bvalid && !bready |=> bvalid); // R10
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rvalid && !rready |=> rvalid && $stable(rdata)); // R10

  always_ff @(posedge clk) begin
    if (rst_n) begin
      AST_BASE_ALIGN: assert (tx_base[8:0] == 9'd0 && rx_other_base[8:0] == 9'd0
                              && rx_data_base[8:0] == 9'd0); // R1
    end
  end
endmodule

bind sata_bridge_regs sbr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_reset(ctl_reset),
  .ctl_wr(ctl_wr), .rx_count(rx_count), .rx_flag(rx_flag),
  .rx_nondata_stb(rx_nondata_stb), .clr_flag(clr_flag), .d2p_done(d2p_done),
  .p2d_done(p2d_done), .clr_d2p(clr_d2p), .clr_p2d(clr_p2d),
  .irq_d2p(irq_d2p), .irq_p2d(irq_p2d), .tx_base(tx_base),
  .rx_other_base(rx_other_base), .rx_data_base(rx_data_base),
  .bvalid(bvalid), .bready(bready), .bresp(bresp), .rvalid(rvalid),
  .rready(rready), .rresp(rresp), .rdata(rdata)
);

// File: tb/test_sata_bridge_regs.sv
module test_sata_bridge_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0, err_code = 32'h0000_00A5;
  logic [3:0] wstrb = 4'hF;
  logic rx_word_stb = 0, rx_nondata_stb = 0, d2p_done = 0, p2d_done = 0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata, tx_base, rx_other_base, rx_data_base;
  logic ctl_fis_data, ctl_start, ctl_reset, irq_d2p, irq_p2d;
  logic [15:0] ctl_tx_words;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sata_bridge_regs #(.ADDR_W(AW)) i_sata_bridge_regs (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read words as rvalid appears
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("R10 unexpected rvalid", 32'd1, 32'd0);
      else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        chk("R9 rresp", {30'd0, rresp}, 32'd0);
      end
    end
  end

  // returns at the falling edge after the accepting edge
  task automatic axw(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R10 bvalid after write", {31'd0, bvalid}, 32'd1);
    chk("R9 bresp", {30'd0, bresp}, 32'd0);
  endtask

  task automatic axr(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    araddr = a; arvalid = 1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 tx_base", tx_base, 0);
    chk("R11 ctl", {ctl_fis_data, ctl_start, ctl_reset, irq_d2p, irq_p2d, ctl_tx_words}, 0);
    axr(8'h0C, 32'h0, "R11 status word");
    axr(8'h04, 32'h0000_00A5, "R4 error code");

    // R1 bases, low nine bits dropped
    axw(8'h00, 32'h1234_56FF, 4'hF);
    chk("R1 tx_base", tx_base, 32'h1234_5600);
    axw(8'h04, 32'h1000_03FF, 4'hF);
    chk("R1 rx_other_base", rx_other_base, 32'h1000_0200);
    axw(8'h0C, 32'h2000_0000, 4'hF);
    chk("R1 rx_data_base", rx_data_base, 32'h2000_0000);

    // R2 / R3 control word with start
    axw(8'h08, 32'h6000_0040, 4'hF);
    chk("R3 start pulse", {31'd0, ctl_start}, 1);
    chk("R3 no reset pulse", {31'd0, ctl_reset}, 0);
    chk("R2 tx words", {16'd0, ctl_tx_words}, 32'h40);
    chk("R2 type data", {31'd0, ctl_fis_data}, 1);
    @(negedge clk);
    chk("R3 start is one cycle", {31'd0, ctl_start}, 0);
    axr(8'h08, 32'h0, "R3 control reads zero");

    // R3 reset pulse
    axw(8'h08, 32'h8000_0040, 4'hF);
    chk("R3 reset pulse", {31'd0, ctl_reset}, 1);
    chk("R2 type other", {31'd0, ctl_fis_data}, 0);
    @(negedge clk);
    chk("R3 reset one cycle", {31'd0, ctl_reset}, 0);

    // R2 byte strobes: only low bytes update, no start
    axw(8'h08, 32'h6000_1234, 4'b0011);
    chk("R2 strobe words", {16'd0, ctl_tx_words}, 32'h1234);
    chk("R2 strobe type kept", {31'd0, ctl_fis_data}, 0);
    chk("R3 no start without strobe", {31'd0, ctl_start}, 0);

    // R5 count
    rx_word_stb = 1;
    repeat (5) @(negedge clk);
    rx_word_stb = 0;
    axr(8'h0C, 32'h0000_0005, "R5 count five");
    // R7 flag
    rx_nondata_stb = 1; @(negedge clk); rx_nondata_stb = 0;
    axr(8'h0C, 32'h8000_0005, "R7 flag set");
    axw(8'h10, 32'h2000_0000, 4'hF);
    axr(8'h0C, 32'h0000_0005, "R7 flag cleared");
    // R7 set wins over clear
    rx_nondata_stb = 1;
    axw(8'h10, 32'h2000_0000, 4'hF);
    rx_nondata_stb = 0;
    axr(8'h0C, 32'h8000_0005, "R7 set wins");
    axw(8'h10, 32'h2000_0000, 4'hF);

    // R6 clear wins over increment
    rx_word_stb = 1;
    @(negedge clk);
    axw(8'h08, 32'h0000_0000, 4'h0);
    rx_word_stb = 0;
    axr(8'h0C, 32'h0, "R6 count cleared");

    // R8 interrupts
    d2p_done = 1; p2d_done = 1; @(negedge clk); d2p_done = 0; p2d_done = 0;
    repeat (3) @(negedge clk);
    chk("R8 irq_d2p held", {31'd0, irq_d2p}, 1);
    chk("R8 irq_p2d held", {31'd0, irq_p2d}, 1);
    axw(8'h10, 32'h8000_0000, 4'hF);
    chk("R8 d2p cleared", {31'd0, irq_d2p}, 0);
    chk("R8 p2d kept", {31'd0, irq_p2d}, 1);
    p2d_done = 1;
    axw(8'h10, 32'h4000_0000, 4'hF);
    p2d_done = 0;
    chk("R8 set wins", {31'd0, irq_p2d}, 1);
    axw(8'h10, 32'h4000_0000, 4'hF);
    chk("R8 p2d cleared", {31'd0, irq_p2d}, 0);

    // R9 unmapped
    axw(8'h14, 32'hFFFF_FFFF, 4'hF);
    axw(8'h02, 32'hFFFF_FFFF, 4'hF);
    chk("R9 unmapped write tx_base", tx_base, 32'h1234_5600);
    chk("R9 unmapped write others", {ctl_start, ctl_reset, irq_d2p, irq_p2d, ctl_tx_words}, 32'h1234);
    axr(8'h0C, 32'h0, "R9 unmapped write status");
    axr(8'h14, 32'h0, "R9 unmapped read");
    axr(8'h00, 32'h0, "R9 write-only offset read");

    // R10 response held while bready low
    bready = 0;
    axw(8'h00, 32'h0000_0000, 4'hF);
    @(negedge clk);
    chk("R10 bvalid held", {31'd0, bvalid}, 1);
    bready = 1;
    @(negedge clk);
    chk("R10 bvalid dropped", {31'd0, bvalid}, 0);

    repeat (3) @(negedge clk);
    chk("R10 all reads answered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule